// File: doc/BRIEF.md
# Single-Pair Ethernet PHY Sleep/Wake Controller

This block manages the low-power mode of an automotive single-pair Ethernet PHY. It keeps track of four power states: normal, sleep request, sleep fail and sleep. A management command moves it from normal into a sleep request. In that state it signals low-power intent to the link partner and waits for the partner to agree. If the partner agrees, the block sleeps and drops the regulator-enable output (`inh_o`), so that the external supply switches off. If the partner does not agree in time, the block passes through sleep fail and returns to normal, and it records the failure in a sticky flag.

The block leaves sleep on a wake event. A wake event is either of two strobes from the line receiver (a valid wake-up pulse sequence, or a wake-up request), or a local wake. A local wake is a level on the wake input that stays high for at least 40 µs. Every wake event that comes from the medium is also forwarded to neighbouring PHYs as one 40 µs pulse on the wake output. A local wake is never echoed onto that output.

Top module: `phy_sleep_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block is set to normal (`mode_o` = 0), with `inh_o` = 1, `lps_req_o` = 0, `wake_pin_o` = 0 and `sleep_fail_o` = 0.
- R2: In normal, a `sleep_cmd_i` strobe moves the block at the next edge to sleep request (`mode_o` = 1). `lps_req_o` is 1 only in sleep request. `sleep_cmd_i` has no effect in any other state.
- R3: In sleep request, `lps_ack_i` moves the block to sleep (`mode_o` = 3), unless a wake event arrives in the same cycle. `inh_o` is 0 only in sleep. `lps_ack_i` has no effect outside sleep request.
- R4: If no acknowledge and no wake event arrives for TIMEOUT_CYC cycles of sleep request, the block spends one cycle in sleep fail (`mode_o` = 2) and then returns to normal. `inh_o` stays 1 throughout, and `sleep_fail_o` is set and stays set until reset.
- R5: In sleep, a `rmt_wup_i` or `rmt_wur_i` strobe returns the block to normal at the next edge, with `inh_o` = 1.
- R6: A local wake is `wake_pin_i` held high across 40·CYC_PER_US consecutive clock edges. It wakes the block from sleep within SYNC_STAGES+2 cycles. A shorter high is ignored.
- R7: A wake event (remote strobe or qualified local wake) seen during sleep request aborts the request and returns the block to normal. A wake event takes priority over an acknowledge in the same cycle.
- R8: A `rmt_wup_i` or `rmt_wur_i` strobe in any state drives `wake_pin_o` high from the next cycle for exactly 40·CYC_PER_US cycles.
- R9: A remote strobe that arrives while the forwarded pulse is high neither lengthens nor repeats it. A qualified local wake never drives `wake_pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_cmd_i | input | 1 | One-cycle local sleep command from the management register |
| lps_ack_i | input | 1 | Link partner agrees to the low-power sleep |
| rmt_wup_i | input | 1 | Valid wake-up pulse sequence detected on the medium |
| rmt_wur_i | input | 1 | Wake-up request detected on the medium |
| wake_pin_i | input | 1 | Asynchronous local wake level |
| lps_req_o | output | 1 | Low-power sleep signalling toward the partner |
| inh_o | output | 1 | Regulator enable, high while awake |
| wake_pin_o | output | 1 | Forwarded wake pulse |
| sleep_fail_o | output | 1 | Sticky flag: a sleep request timed out |
| mode_o | output | 2 | Power state: 0 normal, 1 sleep request, 2 sleep fail, 3 sleep |

## Verification
A vector table steps the state machine through several sequences: command then acknowledge, each remote strobe while asleep, a remote abort of a pending request, and commands or acknowledges in states where they must be ignored. These sequences tell legal transitions apart from stray ones. Directed tests drive the wake input high for one edge less than the threshold and then for exactly the threshold, which separates a qualified local wake from noise. The same tests confirm that neither case reaches the wake output. A pulse test places a second remote strobe in the middle of a forwarded pulse, and a priority test sends an acknowledge and a wake in the same cycle. A silent partner exposes the exact timeout cycle and the sticky flag.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL   = 2'd0,
        PM_SLP_REQ  = 2'd1,
        PM_SLP_FAIL = 2'd2,
        PM_SLEEP    = 2'd3
    } pm_state_e;

    // Width in cycles of a 40 us interval at the given clock rate
    function automatic int unsigned wake_cycles(input int unsigned cyc_per_us);
        return 40 * cyc_per_us;
    endfunction

endpackage

// File: rtl/psc_wake_qual.sv
module psc_wake_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned THR_CYC     = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic evt_o
);
    localparam int unsigned CW = $clog2(THR_CYC + 1);
    localparam logic [CW-1:0] THR_M1  = CW'(THR_CYC - 1);
    localparam logic [CW-1:0] THR_TOP = CW'(THR_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic [CW-1:0]          cnt_q;
    logic                   evt_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    // Counts consecutive high samples and saturates at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            if (!lvl)
                cnt_q <= '0;
            else if (cnt_q != THR_TOP)
                cnt_q <= cnt_q + 1'b1;
            evt_q <= lvl && (cnt_q == THR_M1);
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/psc_fwd_pulse.sv
module psc_fwd_pulse #(
    parameter int unsigned WIDTH_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int unsigned CW = $clog2(WIDTH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH_CYC - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (trig_i) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end
        end else begin
            if (cnt_q == LAST)
                active_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pulse_o = active_q;
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
    import psc_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 100000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_cmd_i,
    input  logic      ack_i,
    input  logic      wake_evt_i,
    output pm_state_e state_o,
    output logic      inh_o,
    output logic      lps_req_o,
    output logic      fail_o
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

    pm_state_e     state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic          tmo;
    logic          fail_q;

    assign tmo = (tmr_q == TMO_LAST);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_NORMAL:   if (sleep_cmd_i) state_d = PM_SLP_REQ;
            PM_SLP_REQ: begin
                if (wake_evt_i)  state_d = PM_NORMAL;
                else if (ack_i)  state_d = PM_SLEEP;
                else if (tmo)    state_d = PM_SLP_FAIL;
            end
            PM_SLP_FAIL: state_d = PM_NORMAL;
            PM_SLEEP:    if (wake_evt_i) state_d = PM_NORMAL;
            default:     state_d = PM_NORMAL;
        endcase
    end

    // State register and request timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_NORMAL;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PM_SLP_REQ) tmr_q <= tmr_q + 1'b1;
            else                       tmr_q <= '0;
        end
    end

    // Sticky failure record
    always_ff @(posedge clk) begin
        if (!rst_n)                       fail_q <= 1'b0;
        else if (state_q == PM_SLP_FAIL)  fail_q <= 1'b1;
    end

    // Outputs decoded from the state
    always_comb begin
        inh_o     = 1'b1;
        lps_req_o = 1'b0;
        unique case (state_q)
            PM_NORMAL:   ;
            PM_SLP_REQ:  lps_req_o = 1'b1;
            PM_SLP_FAIL: ;
            PM_SLEEP:    inh_o = 1'b0;
            default:     ;
        endcase
    end

    assign state_o = state_q;
    assign fail_o  = fail_q;
endmodule

// File: rtl/phy_sleep_ctrl.sv
module phy_sleep_ctrl
    import psc_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 100,
    parameter int unsigned TIMEOUT_CYC = 100000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_cmd_i,
    input  logic       lps_ack_i,
    input  logic       rmt_wup_i,
    input  logic       rmt_wur_i,
    input  logic       wake_pin_i,
    output logic       lps_req_o,
    output logic       inh_o,
    output logic       wake_pin_o,
    output logic       sleep_fail_o,
    output logic [1:0] mode_o
);
    localparam int unsigned WAKE_CYC = wake_cycles(CYC_PER_US);

    logic      rmt_evt;
    logic      loc_evt;
    logic      wake_evt;
    pm_state_e state;

    assign rmt_evt  = rmt_wup_i | rmt_wur_i;
    assign wake_evt = rmt_evt | loc_evt;

    psc_wake_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .THR_CYC     (WAKE_CYC)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (wake_pin_i),
        .evt_o (loc_evt)
    );

    // Only events from the medium are forwarded
    psc_fwd_pulse #(
        .WIDTH_CYC (WAKE_CYC)
    ) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (rmt_evt),
        .pulse_o (wake_pin_o)
    );

    psc_fsm #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_cmd_i (sleep_cmd_i),
        .ack_i       (lps_ack_i),
        .wake_evt_i  (wake_evt),
        .state_o     (state),
        .inh_o       (inh_o),
        .lps_req_o   (lps_req_o),
        .fail_o      (sleep_fail_o)
    );

    assign mode_o = state;
endmodule

// File: rtl/phy_sleep_ctrl_chk.sv
module phy_sleep_ctrl_chk #(
    parameter int unsigned W_CYC = 4000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_cmd_i,
    input logic       lps_ack_i,
    input logic       rmt_wup_i,
    input logic       rmt_wur_i,
    input logic       lps_req_o,
    input logic       inh_o,
    input logic       wake_pin_o,
    input logic       sleep_fail_o,
    input logic [1:0] mode_o
);
    localparam int unsigned HW = $clog2(W_CYC + 2);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (wake_pin_o) hi_cnt <= hi_cnt + 1'b1;
        else                 hi_cnt <= '0;
    end

    AST_INH_LOW_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_o |-> (mode_o == 2'd3)); // R3

    AST_SLEEP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'd3) && ($past(mode_o) != 2'd3)) |-> ($past(lps_ack_i) && ($past(mode_o) == 2'd1))); // R3

    AST_REQ_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lps_req_o) |-> ($past(sleep_cmd_i) && ($past(mode_o) == 2'd0))); // R2

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep_fail_o) |-> sleep_fail_o); // R4

    AST_FAIL_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> (mode_o == 2'd0)); // R4

    AST_FWD_FROM_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pin_o) |-> $past(rmt_wup_i || rmt_wur_i)); // R9

    AST_FWD_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pin_o |-> (hi_cnt < HW'(W_CYC))); // R8

    AST_RMT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'd3) && (rmt_wup_i || rmt_wur_i)) |=> (mode_o == 2'd0)); // R5
endmodule

bind phy_sleep_ctrl phy_sleep_ctrl_chk #(
    .W_CYC (40 * CYC_PER_US)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_cmd_i  (sleep_cmd_i),
    .lps_ack_i    (lps_ack_i),
    .rmt_wup_i    (rmt_wup_i),
    .rmt_wur_i    (rmt_wur_i),
    .lps_req_o    (lps_req_o),
    .inh_o        (inh_o),
    .wake_pin_o   (wake_pin_o),
    .sleep_fail_o (sleep_fail_o),
    .mode_o       (mode_o)
);

// File: tb/phy_sleep_ctrl_tb.sv
module phy_sleep_ctrl_tb;
    localparam int unsigned CPU  = 2;
    localparam int unsigned TO   = 200;
    localparam int unsigned SYNC = 2;
    localparam int          W    = 40 * CPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_cmd_i = 1'b0;
    logic       lps_ack_i = 1'b0;
    logic       rmt_wup_i = 1'b0;
    logic       rmt_wur_i = 1'b0;
    logic       wake_pin_i = 1'b0;
    logic       lps_req_o, inh_o, wake_pin_o, sleep_fail_o;
    logic [1:0] mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    phy_sleep_ctrl #(
        .CYC_PER_US  (CPU),
        .TIMEOUT_CYC (TO),
        .SYNC_STAGES (SYNC)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_cmd_i  (sleep_cmd_i),
        .lps_ack_i    (lps_ack_i),
        .rmt_wup_i    (rmt_wup_i),
        .rmt_wur_i    (rmt_wur_i),
        .wake_pin_i   (wake_pin_i),
        .lps_req_o    (lps_req_o),
        .inh_o        (inh_o),
        .wake_pin_o   (wake_pin_o),
        .sleep_fail_o (sleep_fail_o),
        .mode_o       (mode_o)
    );

    // Vector: {cmd, ack, wup, wur, exp_mode[1:0], exp_inh, exp_req}
    localparam int NV = 13;
    localparam logic [7:0] VEC [NV] = '{
        8'b0000_00_1_0, // idle: normal                          R2
        8'b1000_01_1_1, // cmd: sleep request                    R2
        8'b0100_11_0_0, // ack: sleep, inh low                   R3
        8'b1000_11_0_0, // cmd ignored in sleep                  R2
        8'b0010_00_1_0, // wake pulse seq: normal                R5
        8'b1000_01_1_1, // cmd                                   R2
        8'b0001_00_1_0, // wake request aborts request           R7
        8'b1000_01_1_1, // cmd                                   R2
        8'b0100_11_0_0, // ack: sleep                            R3
        8'b0001_00_1_0, // wake request from sleep               R5
        8'b0100_00_1_0, // ack ignored in normal                 R3
        8'b1000_01_1_1, // cmd                                   R2
        8'b0110_00_1_0  // ack with wake: wake wins              R7
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic go_sleep();
        @(negedge clk); sleep_cmd_i = 1'b1;
        @(negedge clk); sleep_cmd_i = 1'b0; lps_ack_i = 1'b1;
        @(negedge clk); lps_ack_i = 1'b0;
    endtask

    // Holds the wake input high across n edges, counts forwarded highs
    task automatic local_pulse(input int n, output int fwd_hi);
        fwd_hi = 0;
        @(negedge clk); wake_pin_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wake_pin_o) fwd_hi++;
        end
        wake_pin_i = 1'b0;
        for (int i = 0; i < SYNC + 8; i++) begin
            @(negedge clk);
            if (wake_pin_o) fwd_hi++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, first, seen_fail, inh_drop;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(mode_o == 2'd0, "R1 mode", mode_o, 0);
        chk(inh_o == 1'b1 && lps_req_o == 1'b0, "R1 inh/req", {inh_o, lps_req_o}, 2);
        chk(wake_pin_o == 1'b0 && sleep_fail_o == 1'b0, "R1 wake/fail", {wake_pin_o, sleep_fail_o}, 0);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {sleep_cmd_i, lps_ack_i, rmt_wup_i, rmt_wur_i} = VEC[v][7:4];
            @(negedge clk);
            {sleep_cmd_i, lps_ack_i, rmt_wup_i, rmt_wur_i} = 4'b0;
            chk(mode_o == VEC[v][3:2], $sformatf("R2/R3/R5/R7 vec%0d mode", v), mode_o, VEC[v][3:2]);
            chk(inh_o == VEC[v][1], $sformatf("R3 vec%0d inh", v), inh_o, VEC[v][1]);
            chk(lps_req_o == VEC[v][0], $sformatf("R2 vec%0d req", v), lps_req_o, VEC[v][0]);
        end
        repeat (W + 5) @(negedge clk);

        // R8 pulse width, R9 retrigger ignored
        hi = 0; first = -1;
        @(negedge clk); rmt_wup_i = 1'b1;
        for (int i = 1; i <= W + 20; i++) begin
            @(negedge clk);
            rmt_wup_i = 1'b0;
            rmt_wur_i = (i == 10);
            if (wake_pin_o) begin
                hi++;
                if (first < 0) first = i;
            end
        end
        rmt_wur_i = 1'b0;
        chk(first == 1, "R8 pulse start", first, 1);
        chk(hi == W, "R8 R9 pulse width", hi, W);

        // R6 short local high ignored, and not forwarded
        go_sleep();
        chk(mode_o == 2'd3, "R6 setup sleep", mode_o, 3);
        local_pulse(W - 1, hi);
        chk(mode_o == 2'd3 && inh_o == 1'b0, "R6 short high ignored", mode_o, 3);
        chk(hi == 0, "R9 short not forwarded", hi, 0);

        // R6 full-length local wake
        local_pulse(W, hi);
        chk(mode_o == 2'd0 && inh_o == 1'b1, "R6 local wake", mode_o, 0);
        chk(hi == 0, "R9 local not echoed", hi, 0);

        // R7 local wake aborts pending request
        @(negedge clk); sleep_cmd_i = 1'b1;
        @(negedge clk); sleep_cmd_i = 1'b0;
        local_pulse(W, hi);
        chk(mode_o == 2'd0 && lps_req_o == 1'b0, "R7 local abort", mode_o, 0);
        chk(sleep_fail_o == 1'b0, "R7 no fail flag", sleep_fail_o, 0);

        // R4 timeout
        seen_fail = -1; inh_drop = 0;
        @(negedge clk); sleep_cmd_i = 1'b1;
        for (int i = 1; i <= TO + 4; i++) begin
            @(negedge clk);
            sleep_cmd_i = 1'b0;
            if (!inh_o) inh_drop++;
            if (mode_o == 2'd2 && seen_fail < 0) seen_fail = i;
        end
        chk(seen_fail == TO + 1, "R4 fail cycle", seen_fail, TO + 1);
        chk(inh_drop == 0, "R4 inh held", inh_drop, 0);
        chk(mode_o == 2'd0 && sleep_fail_o == 1'b1, "R4 back to normal sticky", {mode_o, sleep_fail_o}, 1);
        go_sleep();
        chk(sleep_fail_o == 1'b1 && mode_o == 2'd3, "R4 flag stays", sleep_fail_o, 1);

        // R1 reset from sleep clears all
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(mode_o == 2'd0 && inh_o == 1'b1, "R1 reset wakes", mode_o, 0);
        chk(sleep_fail_o == 1'b0, "R1 reset clears flag", sleep_fail_o, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule